// File: doc/BRIEF.md
# State-Qualified Event Generator

This block turns a timer's count and a set of pin levels into a bank of event strobes. Every event slot compares the counter with one of sixteen match registers and watches one input or output pin for a level or an edge. A per-slot combine mode merges the two results. The slot can also be limited to one count direction. A small state register gates the slots: a slot may fire only when its state mask has the bit for the current state.

A firing slot also moves the state register. It either loads its own next-state value or adds that value, and when several slots fire in one cycle the highest-numbered one decides. Each firing sets a sticky flag. Flags are cleared by writing ones, and any flag whose enable bit is set drives the interrupt line. The counter lives outside this block. It supplies its value, its direction, a bidirectional indication and a halt indication, and all events are suppressed while it is halted.

Top module: `state_event_gen`

## Requirements
- R1: Each slot's control word is 21 bits: [3:0] match register select, [7:4] pin select, [8] pin source (1 = output pins, 0 = input pins), [10:9] pin condition, [12:11] combine mode, [14:13] direction qualifier, [15] load select, [20:16] next-state value. Slot i takes bits [i*21 +: 21] of the control bus, and match register k takes bits [k*CNT_W +: CNT_W] of the match bus.
- R2: Combine mode 0 fires on match or pin condition, 1 fires on match alone, 2 fires on the pin condition alone, and 3 fires when both hold.
- R3: Pin condition 3 is true while the pin is high and 0 while it is low. Condition 1 is a rising edge and 2 a falling edge, each taken between the current pin value and the value sampled at the previous clock edge. That sample is taken every cycle, including while halted, and resets to 0.
- R4: When the counter is bidirectional, direction qualifier 1 allows firing only while counting up and 2 only while counting down. Qualifier 0 allows either direction. When the counter is not bidirectional, the qualifier has no effect.
- R5: Slot i can fire only if bit i*32+state of the state mask bus is 1. The state register resets to 0 and changes only on a clock edge at which some slot fires.
- R6: On a firing, the highest-numbered firing slot sets the next state. With load select 1 the state becomes its next-state value; with 0 that value is added to the state modulo 32.
- R7: A firing sets the slot's flag at the next edge. The flag stays set until a write with the clear strobe high and a 1 in that bit position. If a set and a clear hit the same bit in the same cycle, the set wins. Flags reset to 0.
- R8: The interrupt output is high exactly when some flag is set and its enable bit is 1.
- R9: While halt is high no slot fires, and the flags and the state stay unchanged.
- R10: The fire outputs follow the inputs in the same cycle. The state and the flags update at the following rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cntValue | input | CNT_W | Current counter value |
| cntDown | input | 1 | Counter is counting down |
| cntBidir | input | 1 | Counter runs in up/down mode |
| cntHalt | input | 1 | Counter halted; suppresses all events |
| matchRegs | input | 16*CNT_W | Match register values, packed |
| pinIn | input | NUM_IN | Input pin levels |
| pinOut | input | NUM_OUT | Output pin levels |
| evCtrl | input | NUM_EV*21 | Per-slot control words |
| stateMask | input | NUM_EV*32 | Per-slot state masks |
| intEnable | input | NUM_EV | Interrupt enable per flag |
| flagClrWe | input | 1 | Flag clear strobe |
| flagClrData | input | NUM_EV | Flags to clear (ones clear) |
| evFire | output | NUM_EV | Slots firing this cycle |
| evFlags | output | NUM_EV | Sticky event flags |
| irq | output | 1 | Interrupt request |
| stateCur | output | 5 | Current state |

## Verification
The bench uses the default build: 13 slots, a 16-bit count, 8 input pins, 10 output pins and a 5-bit state. With these values, index 9 on the output pins is reachable and the pin-source bit has to select the right bank. The top slot, number 12, can be made to collide with a lower slot, and adding 30 to state 7 shows the wrap at 32. A vector table covers each combine mode, each pin condition and the direction qualifier with bidirectional mode both on and off. Directed steps then walk the state register through load, masked, add and priority cases, and check set-over-clear on a flag and the halt freeze.

// File: rtl/evgen_pkg.sv
package evgen_pkg;
  localparam int STATE_W = 5;
  localparam int MSEL_W  = 4;
  localparam int PSEL_W  = 4;

  typedef enum logic [1:0] {
    CMB_EITHER = 2'd0,
    CMB_MATCH  = 2'd1,
    CMB_PIN    = 2'd2,
    CMB_BOTH   = 2'd3
  } combine_e;

  typedef enum logic [1:0] {
    PC_LOW  = 2'd0,
    PC_RISE = 2'd1,
    PC_FALL = 2'd2,
    PC_HIGH = 2'd3
  } pinCond_e;

  typedef enum logic [1:0] {
    DIR_ANY  = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2,
    DIR_RSVD = 2'd3
  } dirQual_e;

  // condition selection part of a slot control word, bits [14:0]
  typedef struct packed {
    dirQual_e            dirQual;
    combine_e            combine;
    pinCond_e            pinCond;
    logic                useOutput;
    logic [PSEL_W-1:0]   pinSel;
    logic [MSEL_W-1:0]   matchSel;
  } evSel_t;

  // state action part of a slot control word, bits [20:15]
  typedef struct packed {
    logic [STATE_W-1:0]  stateVal;
    logic                loadState;
  } evNext_t;

  localparam int SEL_W  = $bits(evSel_t);
  localparam int NEXT_W = $bits(evNext_t);
  localparam int CTRL_W = SEL_W + NEXT_W;

  // strobes from control to datapath
  typedef struct packed {
    logic                upd;
    logic                load;
    logic [STATE_W-1:0]  val;
  } stateStrobe_t;
endpackage

// File: rtl/evgen_cond.sv
module evgen_cond
  import evgen_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 10
) (
  input  evSel_t                          sel,
  input  logic [CNT_W-1:0]                cntValue,
  input  logic                            cntDown,
  input  logic                            cntBidir,
  input  logic [(1<<MSEL_W)*CNT_W-1:0]    matchRegs,
  input  logic [NUM_IN-1:0]               pinIn,
  input  logic [NUM_OUT-1:0]              pinOut,
  input  logic [NUM_IN-1:0]               prevIn,
  input  logic [NUM_OUT-1:0]              prevOut,
  output logic                            rawHit
);
  localparam int PIN_SPAN = 1 << PSEL_W;

  logic [PIN_SPAN-1:0] inNow, inWas, outNow, outWas;
  logic pinNow, pinWas, pinOk, matchHit, dirOk, combOk;

  assign inNow  = PIN_SPAN'(pinIn);
  assign inWas  = PIN_SPAN'(prevIn);
  assign outNow = PIN_SPAN'(pinOut);
  assign outWas = PIN_SPAN'(prevOut);

  assign pinNow   = sel.useOutput ? outNow[sel.pinSel] : inNow[sel.pinSel];
  assign pinWas   = sel.useOutput ? outWas[sel.pinSel] : inWas[sel.pinSel];
  assign matchHit = (cntValue == matchRegs[sel.matchSel*CNT_W +: CNT_W]);

  always_comb begin
    unique case (sel.pinCond)
      PC_LOW:  pinOk = !pinNow;
      PC_RISE: pinOk = pinNow && !pinWas;
      PC_FALL: pinOk = !pinNow && pinWas;
      default: pinOk = pinNow;
    endcase
  end

  always_comb begin
    unique case (sel.combine)
      CMB_EITHER: combOk = matchHit || pinOk;
      CMB_MATCH:  combOk = matchHit;
      CMB_PIN:    combOk = pinOk;
      default:    combOk = matchHit && pinOk;
    endcase
  end

  always_comb begin
    dirOk = 1'b1;
    if (cntBidir) begin
      if (sel.dirQual == DIR_UP)   dirOk = !cntDown;
      if (sel.dirQual == DIR_DOWN) dirOk = cntDown;
    end
  end

  assign rawHit = combOk && dirOk;
endmodule

// File: rtl/evgen_ctrl.sv
module evgen_ctrl
  import evgen_pkg::*;
#(
  parameter int NUM_EV = 13
) (
  input  logic [NUM_EV-1:0]                  rawVec,
  input  logic [NUM_EV*(1<<STATE_W)-1:0]     stateMask,
  input  logic [NUM_EV*NEXT_W-1:0]           nextBus,
  input  logic [STATE_W-1:0]                 stateCur,
  input  logic                               cntHalt,
  output logic [NUM_EV-1:0]                  fireVec,
  output stateStrobe_t                       strobe
);
  localparam int NUM_STATES = 1 << STATE_W;

  for (genvar i = 0; i < NUM_EV; i++) begin : g_qual
    logic [NUM_STATES-1:0] maskSlice;
    assign maskSlice  = stateMask[i*NUM_STATES +: NUM_STATES];
    assign fireVec[i] = rawVec[i] && maskSlice[stateCur] && !cntHalt;
  end

  // later slots overwrite earlier ones: highest index wins
  always_comb begin
    evNext_t nx;
    strobe = '0;
    for (int i = 0; i < NUM_EV; i++) begin
      nx = evNext_t'(nextBus[i*NEXT_W +: NEXT_W]);
      if (fireVec[i]) begin
        strobe.upd  = 1'b1;
        strobe.load = nx.loadState;
        strobe.val  = nx.stateVal;
      end
    end
  end
endmodule

// File: rtl/evgen_dpath.sv
module evgen_dpath
  import evgen_pkg::*;
#(
  parameter int NUM_EV  = 13,
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cntHalt,
  input  logic [NUM_IN-1:0]   pinIn,
  input  logic [NUM_OUT-1:0]  pinOut,
  input  logic [NUM_EV-1:0]   fireVec,
  input  stateStrobe_t        strobe,
  input  logic                flagClrWe,
  input  logic [NUM_EV-1:0]   flagClrData,
  input  logic [NUM_EV-1:0]   intEnable,
  output logic [NUM_IN-1:0]   prevIn,
  output logic [NUM_OUT-1:0]  prevOut,
  output logic [STATE_W-1:0]  stateReg,
  output logic [NUM_EV-1:0]   flags,
  output logic                irq
);
  logic [NUM_EV-1:0] clrMask;
  assign clrMask = flagClrWe ? flagClrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIn  <= '0;
      prevOut <= '0;
    end else begin
      prevIn  <= pinIn;
      prevOut <= pinOut;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           stateReg <= '0;
    else if (strobe.upd) stateReg <= strobe.load ? strobe.val : stateReg + strobe.val;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~clrMask) | fireVec;
  end

  assign irq = |(flags & intEnable);

  assert_halt_silent_R9: assert property (@(posedge clk) disable iff (!rstN)
    cntHalt |-> fireVec == '0);
  assert_halt_state_R9: assert property (@(posedge clk) disable iff (!rstN)
    cntHalt |=> $stable(stateReg));
  assert_idle_state_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(|fireVec) |=> $stable(stateReg));
  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|fireVec) |=> (flags & $past(fireVec)) == $past(fireVec));
  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!(|fireVec) && !flagClrWe) |=> $stable(flags));
endmodule

// File: rtl/state_event_gen.sv
module state_event_gen
  import evgen_pkg::*;
#(
  parameter int NUM_EV  = 13,
  parameter int CNT_W   = 16,
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 10
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [CNT_W-1:0]                    cntValue,
  input  logic                                cntDown,
  input  logic                                cntBidir,
  input  logic                                cntHalt,
  input  logic [(1<<MSEL_W)*CNT_W-1:0]        matchRegs,
  input  logic [NUM_IN-1:0]                   pinIn,
  input  logic [NUM_OUT-1:0]                  pinOut,
  input  logic [NUM_EV*CTRL_W-1:0]            evCtrl,
  input  logic [NUM_EV*(1<<STATE_W)-1:0]      stateMask,
  input  logic [NUM_EV-1:0]                   intEnable,
  input  logic                                flagClrWe,
  input  logic [NUM_EV-1:0]                   flagClrData,
  output logic [NUM_EV-1:0]                   evFire,
  output logic [NUM_EV-1:0]                   evFlags,
  output logic                                irq,
  output logic [STATE_W-1:0]                  stateCur
);
  logic [NUM_EV-1:0]        rawVec;
  logic [NUM_EV*NEXT_W-1:0] nextBus;
  logic [NUM_IN-1:0]        prevIn;
  logic [NUM_OUT-1:0]       prevOut;
  stateStrobe_t             strobe;

  for (genvar i = 0; i < NUM_EV; i++) begin : g_slot
    evSel_t slotSel;
    assign slotSel = evSel_t'(evCtrl[i*CTRL_W +: SEL_W]);
    assign nextBus[i*NEXT_W +: NEXT_W] = evCtrl[i*CTRL_W+SEL_W +: NEXT_W];

    evgen_cond #(.CNT_W(CNT_W), .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_cond (
      .sel(slotSel), .cntValue(cntValue), .cntDown(cntDown), .cntBidir(cntBidir),
      .matchRegs(matchRegs), .pinIn(pinIn), .pinOut(pinOut),
      .prevIn(prevIn), .prevOut(prevOut), .rawHit(rawVec[i]));
  end

  evgen_ctrl #(.NUM_EV(NUM_EV)) u_ctrl (
    .rawVec(rawVec), .stateMask(stateMask), .nextBus(nextBus),
    .stateCur(stateCur), .cntHalt(cntHalt), .fireVec(evFire), .strobe(strobe));

  evgen_dpath #(.NUM_EV(NUM_EV), .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_dpath (
    .clk(clk), .rstN(rstN), .cntHalt(cntHalt), .pinIn(pinIn), .pinOut(pinOut),
    .fireVec(evFire), .strobe(strobe), .flagClrWe(flagClrWe),
    .flagClrData(flagClrData), .intEnable(intEnable), .prevIn(prevIn),
    .prevOut(prevOut), .stateReg(stateCur), .flags(evFlags), .irq(irq));
endmodule

// File: tb/state_event_gen_tb.sv
`timescale 1ns/1ps
module state_event_gen_tb;
  localparam int NEV = 13;
  localparam int CW  = 16;
  localparam int WW  = 21;

  logic clk = 1'b0, rstN = 1'b0;
  logic [CW-1:0] cntValue = '0;
  logic cntDown = 1'b0, cntBidir = 1'b0, cntHalt = 1'b0;
  logic [16*CW-1:0] matchRegs;
  logic [7:0] pinIn = 8'h02;
  logic [9:0] pinOut = '0;
  logic [NEV*WW-1:0] evCtrl = '0;
  logic [NEV*32-1:0] stateMask = '0;
  logic [NEV-1:0] intEnable = '0, flagClrData = '0;
  logic flagClrWe = 1'b0;
  logic [NEV-1:0] evFire, evFlags;
  logic irq;
  logic [4:0] stateCur;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  state_event_gen u_dut (.clk(clk), .rstN(rstN), .cntValue(cntValue), .cntDown(cntDown),
    .cntBidir(cntBidir), .cntHalt(cntHalt), .matchRegs(matchRegs), .pinIn(pinIn),
    .pinOut(pinOut), .evCtrl(evCtrl), .stateMask(stateMask), .intEnable(intEnable),
    .flagClrWe(flagClrWe), .flagClrData(flagClrData), .evFire(evFire),
    .evFlags(evFlags), .irq(irq), .stateCur(stateCur));

  typedef struct packed {
    logic [15:0] cnt; logic down; logic bidir; logic halt;
    logic [7:0] pin; logic [9:0] pout; logic [12:0] expFire;
  } vec_t;

  localparam vec_t VECS [20] = '{
    '{16'h0000,1'b0,1'b0,1'b0,8'h02,10'h000,13'h0000},
    '{16'h0100,1'b0,1'b0,1'b0,8'h02,10'h000,13'h0001},
    '{16'h0000,1'b0,1'b0,1'b0,8'h03,10'h000,13'h0002},
    '{16'h0000,1'b0,1'b0,1'b0,8'h00,10'h000,13'h0004},
    '{16'h0000,1'b0,1'b0,1'b0,8'h06,10'h000,13'h0008},
    '{16'h0000,1'b0,1'b0,1'b0,8'h06,10'h000,13'h0000},
    '{16'h0000,1'b0,1'b0,1'b0,8'h02,10'h000,13'h0010},
    '{16'h0101,1'b0,1'b0,1'b0,8'h02,10'h000,13'h0020},
    '{16'h0000,1'b0,1'b0,1'b0,8'h0A,10'h000,13'h0020},
    '{16'h0102,1'b0,1'b0,1'b0,8'h02,10'h000,13'h0000},
    '{16'h0102,1'b0,1'b0,1'b0,8'h0A,10'h000,13'h0060},
    '{16'h0000,1'b0,1'b0,1'b0,8'h02,10'h200,13'h0080},
    '{16'h0103,1'b0,1'b0,1'b0,8'h02,10'h000,13'h0300},
    '{16'h0103,1'b1,1'b0,1'b0,8'h02,10'h000,13'h0300},
    '{16'h0103,1'b0,1'b1,1'b0,8'h02,10'h000,13'h0100},
    '{16'h0103,1'b1,1'b1,1'b0,8'h02,10'h000,13'h0200},
    '{16'h0100,1'b0,1'b0,1'b1,8'h03,10'h000,13'h0000},
    '{16'h0100,1'b0,1'b0,1'b0,8'h03,10'h000,13'h0003},
    '{16'h0000,1'b0,1'b0,1'b1,8'h06,10'h000,13'h0000},
    '{16'h0000,1'b0,1'b0,1'b0,8'h06,10'h000,13'h0000}
  };

  // control word per R1: {val[4:0], load, dir[1:0], comb[1:0], cond[1:0], src, pin[3:0], match[3:0]}
  function automatic logic [WW-1:0] mk(input logic [4:0] val, input logic ld,
      input logic [1:0] dir, input logic [1:0] comb, input logic [1:0] cond,
      input logic src, input logic [3:0] pin, input logic [3:0] msel);
    return {val, ld, dir, comb, cond, src, pin, msel};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] c, input logic h, input logic cw,
                       input logic [12:0] cd, input logic [12:0] ef, input string tag);
    cntValue = c; cntHalt = h; flagClrWe = cw; flagClrData = cd;
    #1 check(tag, 32'(evFire), 32'(ef));
    @(posedge clk); #1;
    cntValue = '0; cntHalt = 1'b0; flagClrWe = 1'b0; flagClrData = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    for (int k = 0; k < 16; k++) matchRegs[k*CW +: CW] = 16'h0100 + 16'(k);
    // phase 1: condition table, every slot enabled in all states, add 0
    evCtrl[0*WW +: WW]  = mk(0,0,0,1,0,0,0,0);
    evCtrl[1*WW +: WW]  = mk(0,0,0,2,3,0,0,15);
    evCtrl[2*WW +: WW]  = mk(0,0,0,2,0,0,1,15);
    evCtrl[3*WW +: WW]  = mk(0,0,0,2,1,0,2,15);
    evCtrl[4*WW +: WW]  = mk(0,0,0,2,2,0,2,15);
    evCtrl[5*WW +: WW]  = mk(0,0,0,0,3,0,3,1);
    evCtrl[6*WW +: WW]  = mk(0,0,0,3,3,0,3,2);
    evCtrl[7*WW +: WW]  = mk(0,0,0,2,3,1,9,15);
    evCtrl[8*WW +: WW]  = mk(0,0,1,1,0,0,0,3);
    evCtrl[9*WW +: WW]  = mk(0,0,2,1,0,0,0,3);
    for (int e = 10; e < NEV; e++) evCtrl[e*WW +: WW] = mk(0,0,0,1,0,0,0,15);
    stateMask = '1;
    doReset();
    // reset state R5 R7 R8
    #1;
    check("R5 reset state", 32'(stateCur), 0);
    check("R7 reset flags", 32'(evFlags), 0);
    check("R8 reset irq", 32'(irq), 0);
    check("R10 reset fire", 32'(evFire), 0);
    for (int v = 0; v < 20; v++) begin
      cntValue = VECS[v].cnt; cntDown = VECS[v].down; cntBidir = VECS[v].bidir;
      cntHalt = VECS[v].halt; pinIn = VECS[v].pin; pinOut = VECS[v].pout;
      #1 check($sformatf("R2/R3/R4/R9/R10 vector %0d", v), 32'(evFire), 32'(VECS[v].expFire));
      @(posedge clk); #1;
    end
    cntValue = '0; cntDown = 0; cntBidir = 0; cntHalt = 0; pinIn = 8'h02; pinOut = '0;

    // phase 2: state machine, flags and interrupt
    for (int e = 0; e < NEV; e++) evCtrl[e*WW +: WW] = mk(0,0,0,1,0,0,0,15);
    stateMask = '0;
    evCtrl[10*WW +: WW] = mk(7,1,0,1,0,0,0,4);  stateMask[10*32 + 0] = 1'b1;
    evCtrl[11*WW +: WW] = mk(30,0,0,1,0,0,0,5); stateMask[11*32 + 7] = 1'b1;
    evCtrl[3*WW +: WW]  = mk(1,1,0,1,0,0,0,6);  stateMask[3*32 + 5]  = 1'b1;
    evCtrl[12*WW +: WW] = mk(9,1,0,1,0,0,0,6);  stateMask[12*32 + 5] = 1'b1;
    evCtrl[4*WW +: WW]  = mk(0,0,0,1,0,0,0,7);  stateMask[4*32 + 9]  = 1'b1;
    evCtrl[0*WW +: WW]  = mk(2,1,0,1,0,0,0,8);  stateMask[0*32 + 9]  = 1'b1;
    doReset();
    #1 check("R5 reset state again", 32'(stateCur), 0);
    apply(16'h0104, 0, 0, 0, 13'h0400, "R10 load fire");
    check("R6 load state", 32'(stateCur), 7);
    check("R7 flag set", 32'(evFlags), 32'h0400);
    apply(16'h0104, 0, 0, 0, 13'h0000, "R5 masked fire");
    check("R5 masked state", 32'(stateCur), 7);
    apply(16'h0105, 0, 0, 0, 13'h0800, "R6 add fire");
    check("R6 add wrap state", 32'(stateCur), 5);
    apply(16'h0106, 0, 0, 0, 13'h1008, "R6 priority fire");
    check("R6 priority state", 32'(stateCur), 9);
    check("R7 sticky flags", 32'(evFlags), 32'h1C08);
    check("R8 irq disabled", 32'(irq), 0);
    intEnable = 13'h1000;
    #1 check("R8 irq enabled", 32'(irq), 1);
    intEnable = 13'h0010;
    #1 check("R8 irq other enable", 32'(irq), 0);
    apply(16'h0107, 0, 1, 13'h1010, 13'h0010, "R7 fire during clear");
    check("R7 set beats clear", 32'(evFlags), 32'h0C18);
    check("R8 irq after set", 32'(irq), 1);
    apply(16'h0000, 0, 1, 13'h0010, 13'h0000, "R7 clear idle");
    check("R7 w1c result", 32'(evFlags), 32'h0C08);
    check("R8 irq after clear", 32'(irq), 0);
    apply(16'h0108, 1, 0, 0, 13'h0000, "R9 halted fire");
    check("R9 halted state", 32'(stateCur), 9);
    check("R9 halted flags", 32'(evFlags), 32'h0C08);
    apply(16'h0108, 0, 0, 0, 13'h0001, "R9 resumed fire");
    check("R6 low slot load", 32'(stateCur), 2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule